// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block holds a small set of recent virtual-to-physical page mappings and translates a 32-bit virtual address within the cycle in which it is presented. The virtual address splits into a 20-bit page number and a 12-bit in-page offset. The page number is compared against every stored mapping at once. On a match the block raises `hit` and drives the physical address. That address is built from the stored 20-bit physical page number with the offset passed through unchanged. The block is fully associative, so any page number may sit in any slot.

When a valid lookup finds no mapping, the block raises a request towards a hardware page-table walker and holds the missing page number until the walker answers. The walker answers either with a refill, which is a page-number pair, or with a fault. A refill lands in the first empty slot. If there is none, it lands in the slot named by a rotating victim pointer. If the refilled page number is already present, that slot is rewritten in place instead. A flush input empties the whole cache in one cycle and takes precedence over a refill arriving in the same cycle.

Top module: `xlat_cache`

## Requirements
- R1: While `lookup_valid` is high and a valid slot holds page number `lookup_va[31:12]`, `hit` is 1 in the same cycle and `lookup_pa` equals {stored physical page number, `lookup_va[11:0]`}. `lookup_pa` carries no meaning while `hit` is 0.
- R2: Up to `ENTRIES` distinct page numbers, in any slots, are all resident at the same time and all hit.
- R3: A cycle with `lookup_valid` high, `hit` low and no request outstanding makes `miss_req` rise at the next clock edge, with `miss_vpn` equal to the missed `lookup_va[31:12]`.
- R4: Once raised, `miss_req` stays high and `miss_vpn` stays unchanged until a cycle with `fill_valid` or `walk_fault` high. `miss_req` is low after that edge, and later misses while it is high are not recorded.
- R5: A refill whose page number is not present goes into the lowest-numbered empty slot if any slot is empty.
- R6: When every slot is full, a refill of a new page number replaces the slot named by the victim pointer. The pointer is 0 after reset. It steps by one, wrapping at `ENTRIES`, on every refill that is written, whichever slot that refill used.
- R7: A refill whose page number is already resident rewrites that slot's physical page number. No other mapping is displaced.
- R8: A cycle with `flush_all` high leaves every slot empty after the clock edge, so every later lookup misses until it is refilled.
- R9: When `flush_all` and `fill_valid` are high in the same cycle, nothing is written and the victim pointer does not move.
- R10: After reset every slot is empty and `miss_req` is low.
- R11: While `lookup_valid` is low, `hit` is 0 and no request is raised, even for a resident page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_valid | input | 1 | A translation is requested this cycle |
| lookup_va | input | 32 | Virtual address to translate |
| hit | output | 1 | Mapping found for the current lookup |
| lookup_pa | output | 32 | Translated physical address, valid with `hit` |
| miss_req | output | 1 | Request to the page-table walker is outstanding |
| miss_vpn | output | 20 | Page number the walker should fetch |
| fill_valid | input | 1 | Walker supplies a mapping this cycle |
| fill_vpn | input | 20 | Virtual page number of the supplied mapping |
| fill_ppn | input | 20 | Physical page number of the supplied mapping |
| walk_fault | input | 1 | Walker reports that no mapping exists |
| flush_all | input | 1 | Invalidate every slot |

## Verification
A corrupted valid bit or page tag shows at the ports on the very next lookup of the affected page: `hit` is wrong in that cycle, and a false miss also raises `miss_req` one edge later. A wrong victim choice or pointer step stays hidden until the cache is full and takes a refill of a new page. It then shows as the wrong resident page missing on the following lookup sweep. So the bench tracks a full model of slot contents and pointer, and after every fill it sweeps lookups over a pool larger than the capacity. A stale or duplicated slot shows as a wrong `lookup_pa` after an in-place update, or as two simultaneous matches that the checker flags at once.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  // page number field of a virtual address
  function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  // physical address = stored frame number joined with the untouched offset
  function automatic logic [PA_W-1:0] make_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [VA_W-1:0]  va);
    return {ppn, va[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr_all,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [VPN_W-1:0]                wr_vpn,
  input  logic [PPN_W-1:0]                wr_ppn,
  output logic [ENTRIES-1:0]              valid_vec,
  output logic [ENTRIES-1:0][VPN_W-1:0]   vpn_arr,
  output logic [ENTRIES-1:0][PPN_W-1:0]   ppn_arr
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)       valid_vec[g] <= 1'b0;
      else if (clr_all) valid_vec[g] <= 1'b0;
      else if (sel)     valid_vec[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vpn_arr[g] <= '0;
        ppn_arr[g] <= '0;
      end else if (sel) begin
        vpn_arr[g] <= wr_vpn;
        ppn_arr[g] <= wr_ppn;
      end
    end
  end
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic [VPN_W-1:0]              key,
  input  logic [ENTRIES-1:0]            valid_vec,
  input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_arr,
  output logic [ENTRIES-1:0]            match_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] && (vpn_arr[g] == key);
  end
endmodule

// File: rtl/xlat_slot_pick.sv
module xlat_slot_pick #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] dup_vec,
  output logic [IDX_W-1:0]   slot_idx,
  output logic [IDX_W-1:0]   victim_ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic             has_dup, has_free;
  logic [IDX_W-1:0] dup_idx, free_idx;

  always_comb begin
    has_dup  = |dup_vec;
    has_free = ~&valid_vec;
    dup_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (dup_vec[i])    dup_idx  = IDX_W'(i);
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
    if (has_dup)       slot_idx = dup_idx;
    else if (has_free) slot_idx = free_idx;
    else               slot_idx = victim_ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       victim_ptr <= '0;
    else if (advance) victim_ptr <= (victim_ptr == LAST) ? '0 : victim_ptr + 1'b1;
  end
endmodule

// File: rtl/xlat_miss_ctl.sv
module xlat_miss_ctl
  import xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lookup_miss,
  input  logic [VPN_W-1:0] lookup_vpn,
  input  logic             answer,
  output logic             miss_req,
  output logic [VPN_W-1:0] miss_vpn
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_req <= 1'b0;
      miss_vpn <= '0;
    end else if (miss_req) begin
      if (answer) miss_req <= 1'b0;
    end else if (lookup_miss) begin
      miss_req <= 1'b1;
      miss_vpn <= lookup_vpn;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lookup_valid,
  input  logic [VA_W-1:0]  lookup_va,
  output logic             hit,
  output logic [PA_W-1:0]  lookup_pa,
  output logic             miss_req,
  output logic [VPN_W-1:0] miss_vpn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             walk_fault,
  input  logic             flush_all
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // named internal events, also seen by the bound checker
  logic [ENTRIES-1:0]            valid_vec;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_arr;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_arr;
  logic [ENTRIES-1:0]            look_match;
  logic [ENTRIES-1:0]            fill_match;
  logic [IDX_W-1:0]              slot_idx;
  logic [IDX_W-1:0]              victim_ptr;
  logic                          wr_fire;
  logic                          lookup_miss;
  logic [PPN_W-1:0]              ppn_sel;

  assign wr_fire = fill_valid && !flush_all;   // flush has priority

  xlat_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_all(flush_all), .wr_en(wr_fire),
    .wr_idx(slot_idx), .wr_vpn(fill_vpn), .wr_ppn(fill_ppn),
    .valid_vec(valid_vec), .vpn_arr(vpn_arr), .ppn_arr(ppn_arr)
  );

  xlat_cam #(.ENTRIES(ENTRIES)) u_look_cam (
    .key(page_of(lookup_va)), .valid_vec(valid_vec), .vpn_arr(vpn_arr),
    .match_vec(look_match)
  );

  xlat_cam #(.ENTRIES(ENTRIES)) u_fill_cam (
    .key(fill_vpn), .valid_vec(valid_vec), .vpn_arr(vpn_arr),
    .match_vec(fill_match)
  );

  xlat_slot_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .advance(wr_fire), .valid_vec(valid_vec),
    .dup_vec(fill_match), .slot_idx(slot_idx), .victim_ptr(victim_ptr)
  );

  always_comb begin
    ppn_sel = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (look_match[i]) ppn_sel = ppn_sel | ppn_arr[i];
  end

  assign hit         = lookup_valid && (|look_match);
  assign lookup_pa   = make_pa(ppn_sel, lookup_va);
  assign lookup_miss = lookup_valid && !(|look_match);

  xlat_miss_ctl u_miss (
    .clk(clk), .rst_n(rst_n), .lookup_miss(lookup_miss),
    .lookup_vpn(page_of(lookup_va)), .answer(fill_valid || walk_fault),
    .miss_req(miss_req), .miss_vpn(miss_vpn)
  );
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lookup_valid,
  input logic               hit,
  input logic               miss_req,
  input logic [VPN_W-1:0]   miss_vpn,
  input logic               fill_valid,
  input logic               walk_fault,
  input logic               flush_all,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] look_match,
  input logic [IDX_W-1:0]   victim_ptr
);
  // R3
  miss_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_req) |-> $past(lookup_valid && !hit));

  // R4
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req && !fill_valid && !walk_fault) |=> (miss_req && $stable(miss_vpn)));

  // R4
  miss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req && (fill_valid || walk_fault)) |=> !miss_req);

  // R7
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));

  // R9
  flush_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> $stable(victim_ptr));

  // R11
  idle_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |-> !hit);
endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .hit(hit),
  .miss_req(miss_req), .miss_vpn(miss_vpn), .fill_valid(fill_valid),
  .walk_fault(walk_fault), .flush_all(flush_all), .valid_vec(valid_vec),
  .look_match(look_match), .victim_ptr(victim_ptr)
);

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int ENT  = 4;
  localparam int POOL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookup_valid = 1'b0;
  logic [31:0] lookup_va = '0;
  logic        hit;
  logic [31:0] lookup_pa;
  logic        miss_req;
  logic [19:0] miss_vpn;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic        walk_fault = 1'b0;
  logic        flush_all = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  xlat_cache #(.ENTRIES(ENT)) u_xlat_cache (
    .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .lookup_va(lookup_va),
    .hit(hit), .lookup_pa(lookup_pa), .miss_req(miss_req), .miss_vpn(miss_vpn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .walk_fault(walk_fault), .flush_all(flush_all)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model state
  bit          m_val [ENT];
  logic [19:0] m_vpn [ENT];
  logic [19:0] m_ppn [ENT];
  int          m_ptr;
  bit          m_pend;
  logic [19:0] m_mvpn;

  function automatic logic [19:0] vpn_of(int k);
    return 20'h00A00 + 20'(k) * 20'h01357;
  endfunction

  function automatic logic [19:0] ppn_of(int k, int gen);
    return 20'h80000 ^ (20'(k) << 4) ^ 20'(gen * 20'h00301);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit lv, logic [19:0] vpn, logic [11:0] off,
                      bit fv, logic [19:0] fvpn, logic [19:0] fppn, bit flt, bit fl);
    bit          e_hit;
    logic [19:0] e_ppn;
    int          slot;
    bit          found;
    @(negedge clk);
    lookup_valid = lv; lookup_va = {vpn, off};
    fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn;
    walk_fault = flt; flush_all = fl;
    #5;
    e_hit = 1'b0; e_ppn = '0;
    for (int i = 0; i < ENT; i++)
      if (lv && m_val[i] && m_vpn[i] == vpn) begin e_hit = 1'b1; e_ppn = m_ppn[i]; end
    chk(tag, "hit", 32'(hit), 32'(e_hit));
    if (e_hit) chk(tag, "lookup_pa", lookup_pa, {e_ppn, off});
    chk(tag, "miss_req", 32'(miss_req), 32'(m_pend));
    if (m_pend) chk(tag, "miss_vpn", 32'(miss_vpn), 32'(m_mvpn));
    // advance the model to the state after this edge
    if (m_pend) begin
      if (fv || flt) m_pend = 1'b0;
    end else if (lv && !e_hit) begin
      m_pend = 1'b1; m_mvpn = vpn;
    end
    if (fl) begin
      for (int i = 0; i < ENT; i++) m_val[i] = 1'b0;
    end else if (fv) begin
      found = 1'b0; slot = m_ptr;
      for (int i = ENT - 1; i >= 0; i--)
        if (m_val[i] && m_vpn[i] == fvpn) begin found = 1'b1; slot = i; end
      if (!found)
        for (int i = ENT - 1; i >= 0; i--)
          if (!m_val[i]) begin found = 1'b1; slot = i; end
      m_val[slot] = 1'b1; m_vpn[slot] = fvpn; m_ppn[slot] = fppn;
      m_ptr = (m_ptr + 1) % ENT;
    end
  endtask

  task automatic look(string tag, logic [19:0] vpn, logic [11:0] off);
    step(tag, 1'b1, vpn, off, 1'b0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic fill(string tag, logic [19:0] vpn, logic [19:0] ppn);
    step(tag, 1'b0, '0, '0, 1'b1, vpn, ppn, 1'b0, 1'b0);
  endtask

  task automatic sweep(string tag);
    for (int k = 0; k < POOL; k++) look(tag, vpn_of(k), 12'(k * 12'h1F3 + 12'h005));
    for (int k = 0; k < POOL; k++) look(tag, vpn_of(k), 12'hFFF - 12'(k));
    step(tag, 1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 1'b0);   // clear any request
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < ENT; i++) begin m_val[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0; end
    m_ptr = 0; m_pend = 1'b0; m_mvpn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R10: empty after reset, no request
    step("R10 reset idle", 1'b0, '0, '0, 1'b0, '0, '0, 1'b0, 1'b0);
    sweep("R10 empty after reset");

    // R3 / R4: request raised, held across other misses, dropped on answer
    look("R3 miss raise", vpn_of(2), 12'h123);
    look("R4 hold vs later miss", vpn_of(5), 12'h000);
    step("R4 hold idle", 1'b0, '0, '0, 1'b0, '0, '0, 1'b0, 1'b0);
    step("R4 fault answer", 1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 1'b0);
    step("R4 dropped", 1'b0, '0, '0, 1'b0, '0, '0, 1'b0, 1'b0);
    look("R3 miss again", vpn_of(3), 12'h777);
    fill("R4 fill answer", vpn_of(3), ppn_of(3, 0));
    look("R1 filled page hits", vpn_of(3), 12'hABC);

    // R11: idle lookups of a resident page
    step("R11 idle no hit", 1'b0, vpn_of(3), 12'h010, 1'b0, '0, '0, 1'b0, 1'b0);
    step("R11 idle no request", 1'b0, vpn_of(6), 12'h010, 1'b0, '0, '0, 1'b0, 1'b0);

    // R5 / R2: fill the rest into free slots, all resident together
    for (int k = 0; k < ENT - 1; k++) fill("R5 free slot fill", vpn_of(k), ppn_of(k, 0));
    sweep("R2 full capacity resident");

    // R6: replacement by rotating pointer once full
    fill("R6 victim fill a", vpn_of(4), ppn_of(4, 0));
    sweep("R6 after first victim");
    fill("R6 victim fill b", vpn_of(5), ppn_of(5, 0));
    fill("R6 victim fill c", vpn_of(6), ppn_of(6, 0));
    sweep("R6 after wrap");

    // R7: in-place update of a resident page
    fill("R7 update resident", vpn_of(5), ppn_of(5, 7));
    sweep("R7 no displacement");

    // R8: flush empties the cache
    step("R8 flush", 1'b0, '0, '0, 1'b0, '0, '0, 1'b0, 1'b1);
    sweep("R8 empty after flush");

    // R9: flush beats a same-cycle refill, pointer unmoved
    fill("R9 prefill", vpn_of(1), ppn_of(1, 2));
    step("R9 flush with fill", 1'b0, '0, '0, 1'b1, vpn_of(2), ppn_of(2, 2), 1'b0, 1'b1);
    sweep("R9 nothing written");
    for (int k = 0; k < POOL; k++) fill("R9 R5 refill after flush", vpn_of(k), ppn_of(k, 3));
    sweep("R9 pointer position");

    // R1: mixed traffic against the model
    lf = 16'hACE1;
    for (int n = 0; n < 1500; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R1 mixed traffic", lf[0], vpn_of(int'(lf[4:2])), {lf[11:4], lf[3:0]},
           lf[5] & lf[6], vpn_of(int'(lf[9:7])), ppn_of(int'(lf[9:7]), int'(lf[15:12])),
           lf[10] & lf[11] & ~lf[5], (lf[15:11] == 5'h1F));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule